// File: doc/BRIEF.md
# PHY Control-Register Access Master

This block performs single reads and writes into a PHY's internal control-register space over a slow, hand-driven serial port. It does not send the PHY a free-running clock. It produces each control-clock pulse itself, as a high phase followed by a low phase, and the length of each phase is set by a parameter. Before every access it sends a fixed burst of warm-up pulses. It then raises the select line, presents the 16-bit register address and, for a write, the 16-bit write data. It launches the access by holding one enable strobe over a single pulse.

After the launch the block polls the PHY's acknowledge. Each poll that finds acknowledge low costs one extra control-clock pulse and a programmable wait before the next look. The number of polls is bounded. When acknowledge is found, the block reports completion, and a read also returns the PHY's data word. When the bound is used up, the block reports a timeout. The host side is a start pulse carrying an address, write data and a direction flag. Each access ends in a one-cycle done or timeout pulse.

Top module: `phy_cr_master`

## Requirements
- R1: After `start` is accepted, exactly WARMUP_PULSES (default 100) complete control-clock pulses are sent on `phy_clk`. During these pulses `phy_sel`, `phy_wr_en` and `phy_rd_en` stay low.
- R2: `phy_sel` rises only after the warm-up pulses. It is high on every control-clock rise from the launch pulse onward, and it falls in the cycle that `done` or `timeout` is raised.
- R3: On the rising edge of the launch pulse, `phy_addr` carries the address that was given with the accepted `start`.
- R4: On a write launch, `phy_wdata` carries the accepted write data. On a read launch, `phy_wdata` still holds the value of the most recent write launch (0 after reset).
- R5: The launch pulse is the first control-clock pulse with `phy_sel` high. During it exactly one enable is high: `phy_wr_en` when `wr_req`=1, `phy_rd_en` when `wr_req`=0. Both enables are low on every later pulse.
- R6: After the launch pulse, `phy_ack` is sampled. Each sample that finds it low and is not the last one allowed is followed by one extra control-clock pulse. From the second extra pulse on, the clock stays low for at least PHASE_CYCLES+POLL_GAP_CYCLES system clocks before each rise. When acknowledge first appears after k extra pulses (k < POLL_MAX), exactly k extra pulses are sent.
- R7: `phy_ack` is sampled at most POLL_MAX (default 10) times. If it is low on all of them, `timeout` pulses instead of `done`, after exactly POLL_MAX-1 extra pulses. `done` and `timeout` are never high together.
- R8: When a read completes, `rdata` takes the value of `phy_rdata` that was present when acknowledge was seen. `rdata` does not change on a write completion or on a timeout.
- R9: A `start` raised while an access is in progress is ignored and produces no completion of its own. `done` and `timeout` each last one cycle.
- R10: While `rst` is high, `phy_clk`, `phy_sel`, `phy_wr_en`, `phy_rd_en`, `done` and `timeout` are low and `rdata` is 0.
- R11: Every control-clock high phase lasts exactly PHASE_CYCLES (default 4) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted only when idle |
| wr_req | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Register address for the request |
| wdata | input | 16 | Write data for the request |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle pulse when acknowledge never came |
| rdata | output | 16 | Data returned by the last successful read |
| phy_clk | output | 1 | Hand-pulsed control clock to the PHY |
| phy_sel | output | 1 | Control-port select |
| phy_addr | output | 16 | Register address to the PHY |
| phy_wdata | output | 16 | Write data to the PHY |
| phy_wr_en | output | 1 | Write launch strobe |
| phy_rd_en | output | 1 | Read launch strobe |
| phy_ack | input | 1 | Acknowledge from the PHY |
| phy_rdata | input | 16 | Read data from the PHY |

## Verification
Two decisions can fall on the same poll: the acknowledge arriving, and the poll budget running out. The bench's PHY model raises acknowledge only after a chosen number of extra pulses. Nine extra pulses puts the acknowledge on the final allowed sample, which must produce `done`. Ten puts it one pulse too late, which must produce `timeout` with nine extra pulses counted. A second collision is a `start` arriving while an access is in flight. The bench judges it by checking the address seen at launch and by checking that completions match the accepted requests one for one.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_WARM,
    SQ_SEL,
    SQ_ADDR,
    SQ_DATA,
    SQ_LAUNCH,
    SQ_LAUNCH_W,
    SQ_POLL,
    SQ_POLL_W,
    SQ_GAP
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HIGH,
    PH_LOW
  } phase_state_t;
endpackage

// File: rtl/cr_clk_pulser.sv
module cr_clk_pulser #(
  parameter int PHASE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_req,
  output logic cr_clk,
  output logic pulse_done
);
  import phy_cr_pkg::*;

  localparam int CW = $clog2(PHASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  phase_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      cnt        <= '0;
      cr_clk     <= 1'b0;
      pulse_done <= 1'b0;
    end else begin
      pulse_done <= 1'b0;
      case (st)
        PH_IDLE: if (pulse_req) begin
          cr_clk <= 1'b1;
          cnt    <= '0;
          st     <= PH_HIGH;
        end
        PH_HIGH: if (cnt == LAST) begin
          cr_clk <= 1'b0;
          cnt    <= '0;
          st     <= PH_LOW;
        end else begin
          cnt <= cnt + 1'b1;
        end
        PH_LOW: if (cnt == LAST) begin
          pulse_done <= 1'b1;
          st         <= PH_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R11: a high phase never collapses to a single system clock
  a_r11_high_holds: assert property (@(posedge clk) disable iff (rst)
    ($rose(cr_clk) && (PHASE_CYCLES > 1)) |=> cr_clk);
  // R11: a completed pulse ends with the clock low
  a_r11_done_low: assert property (@(posedge clk) disable iff (rst)
    pulse_done |-> !cr_clk);
endmodule

// File: rtl/cr_wait_timer.sv
module cr_wait_timer #(
  parameter int WAIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int TW = $clog2(WAIT_CYCLES + 1);

  logic [TW-1:0] cnt;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt     <= TW'(WAIT_CYCLES - 1);
        running <= 1'b1;
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R6: expiry is a single-cycle event
  a_r6_expire_pulse: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);
endmodule

// File: rtl/cr_access_seq.sv
module cr_access_seq #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int WARMUP_PULSES = 100,
  parameter int POLL_MAX      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  input  logic              pulse_done,
  input  logic              gap_expired,
  output logic              pulse_req,
  output logic              gap_load,
  output logic              phy_sel,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr_en,
  output logic              phy_rd_en,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] rdata
);
  import phy_cr_pkg::*;

  localparam int WW = $clog2(WARMUP_PULSES + 1);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARMUP_PULSES - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_MAX - 1);

  seq_state_t        st;
  logic [WW-1:0]     warm_cnt;
  logic [PW-1:0]     poll_cnt;
  logic              lat_we;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      warm_cnt  <= '0;
      poll_cnt  <= '0;
      lat_we    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      pulse_req <= 1'b0;
      gap_load  <= 1'b0;
      phy_sel   <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      phy_wr_en <= 1'b0;
      phy_rd_en <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      rdata     <= '0;
    end else begin
      pulse_req <= 1'b0;
      gap_load  <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          lat_we    <= wr_req;
          lat_addr  <= addr;
          lat_wdata <= wdata;
          warm_cnt  <= '0;
          pulse_req <= 1'b1;
          st        <= SQ_WARM;
        end
        SQ_WARM: if (pulse_done) begin
          if (warm_cnt == WARM_LAST) begin
            st <= SQ_SEL;
          end else begin
            warm_cnt  <= warm_cnt + 1'b1;
            pulse_req <= 1'b1;
          end
        end
        SQ_SEL: begin
          phy_sel <= 1'b1;
          st      <= SQ_ADDR;
        end
        SQ_ADDR: begin
          phy_addr <= lat_addr;
          st       <= SQ_DATA;
        end
        SQ_DATA: begin
          if (lat_we) phy_wdata <= lat_wdata;
          st <= SQ_LAUNCH;
        end
        SQ_LAUNCH: begin
          phy_wr_en <= lat_we;
          phy_rd_en <= !lat_we;
          pulse_req <= 1'b1;
          st        <= SQ_LAUNCH_W;
        end
        SQ_LAUNCH_W: if (pulse_done) begin
          phy_wr_en <= 1'b0;
          phy_rd_en <= 1'b0;
          poll_cnt  <= '0;
          st        <= SQ_POLL;
        end
        SQ_POLL: begin
          if (phy_ack) begin
            if (!lat_we) rdata <= phy_rdata;
            done    <= 1'b1;
            phy_sel <= 1'b0;
            st      <= SQ_IDLE;
          end else if (poll_cnt == POLL_LAST) begin
            timeout <= 1'b1;
            phy_sel <= 1'b0;
            st      <= SQ_IDLE;
          end else begin
            poll_cnt  <= poll_cnt + 1'b1;
            pulse_req <= 1'b1;
            st        <= SQ_POLL_W;
          end
        end
        SQ_POLL_W: if (pulse_done) begin
          gap_load <= 1'b1;
          st       <= SQ_GAP;
        end
        SQ_GAP: if (gap_expired) st <= SQ_POLL;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R5: the two launch strobes are never high together
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(phy_wr_en && phy_rd_en));
  // R2: a strobe is only ever raised with select already high
  a_r2_strobe_has_sel: assert property (@(posedge clk) disable iff (rst)
    (phy_wr_en || phy_rd_en) |-> phy_sel);
  // R7: completion and timeout are exclusive
  a_r7_exclusive_end: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));
  // R9: completion pulses last one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
  // R2: select drops together with the end of the access
  a_r2_sel_drops: assert property (@(posedge clk) disable iff (rst)
    (done || timeout) |-> !phy_sel);
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master #(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 16,
  parameter int WARMUP_PULSES   = 100,
  parameter int PHASE_CYCLES    = 4,
  parameter int POLL_MAX        = 10,
  parameter int POLL_GAP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic              timeout,
  output logic [DATA_W-1:0] rdata,
  output logic              phy_clk,
  output logic              phy_sel,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  output logic              phy_wr_en,
  output logic              phy_rd_en,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata
);
  logic pulse_req;
  logic pulse_done;
  logic gap_load;
  logic gap_expired;

  cr_clk_pulser #(.PHASE_CYCLES(PHASE_CYCLES)) u_pulser (
    .clk        (clk),
    .rst        (rst),
    .pulse_req  (pulse_req),
    .cr_clk     (phy_clk),
    .pulse_done (pulse_done)
  );

  cr_wait_timer #(.WAIT_CYCLES(POLL_GAP_CYCLES)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .expired (gap_expired)
  );

  cr_access_seq #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .WARMUP_PULSES (WARMUP_PULSES),
    .POLL_MAX      (POLL_MAX)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .wr_req      (wr_req),
    .addr        (addr),
    .wdata       (wdata),
    .phy_ack     (phy_ack),
    .phy_rdata   (phy_rdata),
    .pulse_done  (pulse_done),
    .gap_expired (gap_expired),
    .pulse_req   (pulse_req),
    .gap_load    (gap_load),
    .phy_sel     (phy_sel),
    .phy_addr    (phy_addr),
    .phy_wdata   (phy_wdata),
    .phy_wr_en   (phy_wr_en),
    .phy_rd_en   (phy_rd_en),
    .done        (done),
    .timeout     (timeout),
    .rdata       (rdata)
  );
endmodule

// File: tb/phy_cr_master_bench.sv
module phy_cr_master_bench;
  localparam int WARM  = 100;
  localparam int PHASE = 4;
  localparam int POLLS = 10;
  localparam int GAP   = 8;

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [15:0] data;
    int          k;
    bit          exp_to;
    logic [15:0] exp_rdata;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        wr_req = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        done, timeout;
  logic [15:0] rdata;
  logic        phy_clk, phy_sel, phy_wr_en, phy_rd_en;
  logic [15:0] phy_addr, phy_wdata;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_rdata = '0;

  int checks = 0;
  int fails  = 0;
  int issued = 0;
  int completed = 0;
  int cur_k = 0;
  item_t q[$];
  logic [15:0] ref_mem[logic [15:0]];
  logic [15:0] model_mem[logic [15:0]];
  logic [15:0] last_rd = '0;

  always #2.5 clk = ~clk;

  phy_cr_master #(
    .ADDR_W(16), .DATA_W(16), .WARMUP_PULSES(WARM),
    .PHASE_CYCLES(PHASE), .POLL_MAX(POLLS), .POLL_GAP_CYCLES(GAP)
  ) u_phy_cr_master (
    .clk(clk), .rst(rst), .start(start), .wr_req(wr_req), .addr(addr),
    .wdata(wdata), .done(done), .timeout(timeout), .rdata(rdata),
    .phy_clk(phy_clk), .phy_sel(phy_sel), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_wr_en(phy_wr_en), .phy_rd_en(phy_rd_en),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_read(logic [15:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return a ^ 16'hA5A5;
  endfunction

  // driver: waits for idle, pushes the expected outcome, pulses start
  task automatic access(bit w, logic [15:0] a, logic [15:0] d, int k);
    item_t it;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    it.we = w; it.addr = a; it.data = d; it.k = k;
    it.exp_to = (k >= POLLS);
    if (w) begin
      ref_mem[a] = d;
      it.exp_rdata = last_rd;
    end else if (!it.exp_to) begin
      last_rd = ref_read(a);
      it.exp_rdata = last_rd;
    end else begin
      it.exp_rdata = last_rd;
    end
    q.push_back(it);
    issued++;
    cur_k = k;
    start = 1'b1; wr_req = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  // PHY model and monitor
  bit clk_q = 0;
  bit pending = 0;
  bit pend_we = 0;
  int warm_cnt = 0;
  int post = 0;
  int hi_len = 0;
  int lo_len = 0;
  bit done_q = 0;
  bit to_q = 0;
  logic [15:0] last_wr_launch = '0;

  always @(negedge clk) begin
    if (rst) begin
      clk_q = 0; pending = 0; warm_cnt = 0; post = 0; hi_len = 0; lo_len = 0;
      phy_ack = 1'b0;
    end else begin
      if (phy_clk) hi_len++;
      else begin
        if (hi_len != 0) chk(hi_len == PHASE, "R11", "high phase length", hi_len, PHASE);
        hi_len = 0;
        lo_len++;
      end
      if (phy_clk && !clk_q) begin
        if (phy_wr_en || phy_rd_en) begin
          chk(q.size() != 0, "R9", "launch without accepted request", 0, 1);
          chk(warm_cnt == WARM, "R1", "warm-up pulses before launch", warm_cnt, WARM);
          chk(phy_sel, "R2", "select at launch", phy_sel, 1);
          chk(!(phy_wr_en && phy_rd_en), "R5", "both enables", 1, 0);
          if (q.size() != 0) begin
            chk(phy_addr == q[0].addr, "R3", "launch address", phy_addr, q[0].addr);
            chk(phy_wr_en == q[0].we, "R5", "enable matches direction", phy_wr_en, q[0].we);
            if (q[0].we)
              chk(phy_wdata == q[0].data, "R4", "write data at launch", phy_wdata, q[0].data);
            else
              chk(phy_wdata == last_wr_launch, "R4", "data field kept on read", phy_wdata, last_wr_launch);
          end
          pending = 1; pend_we = phy_wr_en; post = 0;
          if (phy_wr_en) begin
            model_mem[phy_addr] = phy_wdata;
            last_wr_launch = phy_wdata;
          end
        end else if (pending) begin
          if (post >= 1)
            chk(lo_len >= PHASE + GAP, "R6", "low time before poll pulse", lo_len, PHASE + GAP);
          post++;
        end else if (!phy_sel) begin
          warm_cnt++;
        end else begin
          chk(0, "R5", "pulse with select high but no launch", 0, 1);
        end
        lo_len = 0;
      end
      clk_q = phy_clk;
      if (done || timeout) begin
        completed++;
        chk(!(done && timeout), "R7", "done and timeout together", 1, 0);
        chk(!phy_sel, "R2", "select low at end", phy_sel, 0);
        if (q.size() == 0) begin
          chk(0, "R9", "completion without request", 0, 1);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(timeout == it.exp_to, "R7", "timeout outcome", timeout, it.exp_to);
          chk(post == (it.exp_to ? POLLS - 1 : it.k), "R6", "extra poll pulses",
              post, it.exp_to ? POLLS - 1 : it.k);
          chk(rdata == it.exp_rdata, "R8", "rdata after completion", rdata, it.exp_rdata);
        end
        pending = 0; warm_cnt = 0; post = 0;
      end
      if (done_q) chk(!done, "R9", "done single cycle", done, 0);
      if (to_q) chk(!timeout, "R9", "timeout single cycle", timeout, 0);
      done_q = done; to_q = timeout;
      phy_ack = pending && (post >= cur_k);
      if (pending && !pend_we)
        phy_rdata = model_mem.exists(phy_addr) ? model_mem[phy_addr] : (phy_addr ^ 16'hA5A5);
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!phy_clk && !phy_sel && !phy_wr_en && !phy_rd_en, "R10", "PHY lines in reset",
        {phy_clk, phy_sel, phy_wr_en, phy_rd_en}, 0);
    chk(!done && !timeout && rdata == 0, "R10", "host outputs in reset",
        {done, timeout, rdata}, 0);
    rst = 1'b0;
    access(1, 16'h000F, 16'h1234, 0);      // R4 plain write
    access(0, 16'h000F, 16'h0000, 2);      // R8 read back
    access(0, 16'hBEEF, 16'h0000, 1);      // R8 unwritten register
    access(1, 16'h0021, 16'hC3C3, 9);      // R6 ack on last allowed sample
    access(0, 16'h0021, 16'h0000, 10);     // R7 ack one pulse too late
    access(1, 16'h0030, 16'h7777, 15);     // R7 write timeout, rdata held
    // R9: second start while busy must be ignored
    fork
      access(1, 16'h0042, 16'h5555, 3);
      begin
        repeat (60) @(negedge clk);
        start = 1'b1; wr_req = 1'b0; addr = 16'h0099; wdata = 16'hDEAD;
        @(negedge clk);
        start = 1'b0;
      end
    join
    access(0, 16'h0042, 16'h0000, 0);
    access(1, 16'hFFFF, 16'hFFFF, 4);
    access(0, 16'hFFFF, 16'h0000, 5);
    while (q.size() != 0) @(negedge clk);
    repeat (2000) @(negedge clk);
    chk(completed == issued, "R9", "completions match accepted requests", completed, issued);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule